// File: doc/BRIEF.md
# Priority Interrupt Request Selector

At every instruction boundary the processor has to decide whether an interrupt is taken, and which vector is used. This block makes that decision. There are two kinds of source. The first is a software request word, in which each priority level 1 to 7 has one request bit. The second is a set of device request lines, one per level, and each line comes with a vector supplied by the device. Only levels strictly above the current processor priority can win. They are examined from the top level downward, and the first level with anything pending is granted.

Within one level, a pending software request beats any device request at that level. A software grant always uses the fixed shared vector 0xA0 and acknowledges no device. A device grant uses that device's vector and sends a one-cycle acknowledge on that level's line only. Any grant also produces a wake pulse when the processor is parked waiting for an interrupt.

The decision is combinational from inputs that are assumed to come from registers. It is captured into registered outputs by a single evaluate strobe, so each result appears in the cycle after the strobe.

Top module: `irq_priority_sel`

## Requirements
- R1: While reset is high, and in the first cycle after it, `take_o`, `wake_o` and `ack_o` are all zero and `vec_o` is zero.
- R2: A request at level L is eligible only when L is strictly greater than `cpu_pri_i`. With `cpu_pri_i` = 7, nothing is ever taken.
- R3: Among the eligible levels, the highest one that has a software or device request pending is granted.
- R4: The software request for level L is bit 8+L of `pirq_i`. If it is pending at the granted level, `vec_o` = 0xA0 and `ack_o` is all zero, even when a device at that level is also requesting.
- R5: If no software request is pending at the granted level, `vec_o` equals that level's device vector. The device vector for level L is `dev_vec_i[L*VEC_W +: VEC_W]`. In the same cycle, `ack_o` has exactly bit L set.
- R6: When no eligible request is pending, `take_o` is low and `ack_o` is all zero.
- R7: The outputs reflect the inputs sampled at the clock edge where `eval_i` is high, and they appear in the following cycle. In any cycle after an edge where `eval_i` was low, `take_o`, `ack_o` and `wake_o` are low.
- R8: `wake_o` is high exactly when `take_o` is high and `cpu_wait_i` was high at the evaluating edge.
- R9: Bits 0 to 8 of `pirq_i` and the level-0 device line never cause a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Instruction-boundary evaluate strobe |
| pirq_i | input | PIRQ_W (16) | Software request word; bit 8+L requests level L |
| dev_req_i | input | LEVELS (8) | Device request per level; bit 0 is unused |
| dev_vec_i | input | LEVELS*VEC_W (72) | Device vectors, one VEC_W slice per level |
| cpu_pri_i | input | PRI_W (3) | Current processor priority |
| cpu_wait_i | input | 1 | Processor is waiting for an interrupt |
| take_o | output | 1 | Interrupt granted this cycle |
| vec_o | output | VEC_W (9) | Vector of the granted interrupt |
| ack_o | output | LEVELS (8) | One-hot device acknowledge for the granted level |
| wake_o | output | 1 | Release from the wait-for-interrupt state |

## Verification
Every cycle, the assertions check the following. The acknowledge is one-hot, and it only comes with a grant. A grant only happens after a strobe. An acknowledged level lies above the priority that was sampled. A grant with no acknowledge carries the shared software vector. Wake never fires without a grant.

Some behaviours only show up in the bench's sweeps. These are the choice of the highest level, software winning over a device at the same level, the exact device vector, and the fact that the low request bits are ignored. The sweeps cover all priorities, all software request patterns and a spread of device patterns. For each case, the bench computes the winner arithmetically.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SOFT = 2'd1,
    SRC_DEV  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_level_cand.sv
module irq_level_cand #(
  parameter int LEVELS = 8,
  parameter int PRI_W  = 3,
  parameter int PIRQ_W = 16
) (
  input  logic [PIRQ_W-1:0] pirq_i,
  input  logic [LEVELS-1:0] dev_req_i,
  input  logic [PRI_W-1:0]  cpu_pri_i,
  output logic [LEVELS-1:0] soft_pend_o,
  output logic [LEVELS-1:0] dev_pend_o,
  output logic [LEVELS-1:0] any_pend_o
);
  localparam int SOFT_BASE = PIRQ_W - LEVELS;

  assign soft_pend_o[0] = 1'b0;
  assign dev_pend_o[0]  = 1'b0;
  assign any_pend_o[0]  = 1'b0;

  for (genvar l = 1; l < LEVELS; l++) begin : g_lvl
    logic above;
    assign above          = (PRI_W'(l) > cpu_pri_i);
    assign soft_pend_o[l] = above & pirq_i[SOFT_BASE + l];
    assign dev_pend_o[l]  = above & dev_req_i[l];
    assign any_pend_o[l]  = soft_pend_o[l] | dev_pend_o[l];
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int LEVELS = 8,
  parameter int LVL_W  = 3
) (
  input  logic [LEVELS-1:0] any_pend_i,
  output logic              found_o,
  output logic [LVL_W-1:0]  lvl_o
);
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    for (int l = 1; l < LEVELS; l++) begin
      if (any_pend_i[l]) begin
        found_o = 1'b1;
        lvl_o   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux
  import irq_sel_pkg::*;
#(
  parameter int LEVELS = 8,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 9,
  parameter logic [VEC_W-1:0] SOFT_VEC = 9'h0A0
) (
  input  logic                    found_i,
  input  logic [LVL_W-1:0]        lvl_i,
  input  logic [LEVELS-1:0]       soft_pend_i,
  input  logic [LEVELS*VEC_W-1:0] dev_vec_i,
  output irq_src_e                src_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [LEVELS-1:0]       ack_o
);
  logic [VEC_W-1:0] dev_sel;
  assign dev_sel = dev_vec_i[lvl_i*VEC_W +: VEC_W];

  always_comb begin
    src_o = SRC_NONE;
    vec_o = '0;
    ack_o = '0;
    if (found_i) begin
      if (soft_pend_i[lvl_i]) begin
        src_o = SRC_SOFT;
        vec_o = SOFT_VEC;
      end else begin
        src_o = SRC_DEV;
        vec_o = dev_sel;
        ack_o[lvl_i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_priority_sel.sv
module irq_priority_sel
  import irq_sel_pkg::*;
#(
  parameter int LEVELS = 8,
  parameter int PRI_W  = 3,
  parameter int PIRQ_W = 16,
  parameter int VEC_W  = 9,
  parameter logic [VEC_W-1:0] SOFT_VEC = 9'h0A0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    eval_i,
  input  logic [PIRQ_W-1:0]       pirq_i,
  input  logic [LEVELS-1:0]       dev_req_i,
  input  logic [LEVELS*VEC_W-1:0] dev_vec_i,
  input  logic [PRI_W-1:0]        cpu_pri_i,
  input  logic                    cpu_wait_i,
  output logic                    take_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [LEVELS-1:0]       ack_o,
  output logic                    wake_o
);
  localparam int LVL_W = $clog2(LEVELS);

  logic [LEVELS-1:0] soft_pend, dev_pend, any_pend;
  logic              found;
  logic [LVL_W-1:0]  lvl;
  irq_src_e          src;
  logic [VEC_W-1:0]  vec_c;
  logic [LEVELS-1:0] ack_c;

  irq_level_cand #(.LEVELS(LEVELS), .PRI_W(PRI_W), .PIRQ_W(PIRQ_W)) u_cand (
    .pirq_i(pirq_i), .dev_req_i(dev_req_i), .cpu_pri_i(cpu_pri_i),
    .soft_pend_o(soft_pend), .dev_pend_o(dev_pend), .any_pend_o(any_pend)
  );

  irq_prio_pick #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_pick (
    .any_pend_i(any_pend), .found_o(found), .lvl_o(lvl)
  );

  irq_vec_mux #(.LEVELS(LEVELS), .LVL_W(LVL_W), .VEC_W(VEC_W), .SOFT_VEC(SOFT_VEC)) u_mux (
    .found_i(found), .lvl_i(lvl), .soft_pend_i(soft_pend), .dev_vec_i(dev_vec_i),
    .src_o(src), .vec_o(vec_c), .ack_o(ack_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      vec_o  <= '0;
      ack_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      take_o <= eval_i & (src != SRC_NONE);
      ack_o  <= eval_i ? ack_c : '0;
      wake_o <= eval_i & (src != SRC_NONE) & cpu_wait_i;
      if (eval_i && src != SRC_NONE) vec_o <= vec_c;
    end
  end

  // checker-side decode of the acknowledged level
  logic [LVL_W-1:0] ack_lvl;
  always_comb begin
    ack_lvl = '0;
    for (int l = 0; l < LEVELS; l++) if (ack_o[l]) ack_lvl = LVL_W'(l);
  end

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o));
  // R6
  ack_needs_take_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o != '0) |-> take_o);
  // R7
  take_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> (!take_o && ack_o == '0 && !wake_o));
  // R2
  ack_above_pri_chk: assert property (@(posedge clk) disable iff (rst)
    eval_i |=> ((ack_o == '0) || (PRI_W'(ack_lvl) > $past(cpu_pri_i))));
  // R4
  soft_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && ack_o == '0) |-> (vec_o == SOFT_VEC));
  // R8
  wake_needs_take_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> take_o);
endmodule

// File: tb/tb_irq_priority_sel.sv
module tb_irq_priority_sel;
  localparam int LEVELS = 8, PRI_W = 3, PIRQ_W = 16, VEC_W = 9;

  logic clk = 1'b0, rst = 1'b1, eval_i = 1'b0, cpu_wait_i = 1'b0;
  logic [PIRQ_W-1:0] pirq_i = '0;
  logic [LEVELS-1:0] dev_req_i = '0;
  logic [LEVELS*VEC_W-1:0] dev_vec_i;
  logic [PRI_W-1:0] cpu_pri_i = '0;
  logic take_o, wake_o;
  logic [VEC_W-1:0] vec_o;
  logic [LEVELS-1:0] ack_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_priority_sel dut (.*);

  for (genvar l = 0; l < LEVELS; l++) begin : g_vec
    assign dev_vec_i[l*VEC_W +: VEC_W] = VEC_W'(9'h100 + l * 12);
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one strobed evaluation; s and d are per-level bit patterns for levels 1..7
  task automatic run_one(int pri, logic [7:0] s, logic [7:0] d, logic junk, logic wt);
    int win;
    logic soft_win;
    @(negedge clk);
    cpu_pri_i  = PRI_W'(pri);
    pirq_i     = {s[7:1], 1'b0, junk ? 8'hFF : 8'h00} | (junk ? 16'h0100 : 16'h0);
    dev_req_i  = {d[7:1], junk};
    cpu_wait_i = wt;
    eval_i     = 1'b1;
    win = 0; soft_win = 1'b0;
    for (int l = 7; l > pri; l--) begin
      if (win == 0 && (s[l] || d[l])) begin
        win = l; soft_win = s[l];
      end
    end
    @(negedge clk);
    eval_i = 1'b0;
    if (win == 0) begin
      chk("R6/R2/R9 take", 32'(take_o), 0);
      chk("R6 ack", 32'(ack_o), 0);
    end else begin
      chk("R3 take", 32'(take_o), 1);
      if (soft_win) begin
        chk("R4 vec", 32'(vec_o), 32'h0A0);
        chk("R4 ack", 32'(ack_o), 0);
      end else begin
        chk("R5 vec", 32'(vec_o), 32'h100 + win * 12);
        chk("R5 ack", 32'(ack_o), 32'(1 << win));
      end
    end
    chk("R8 wake", 32'(wake_o), 32'((win != 0) && wt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 take", 32'(take_o), 0);
    chk("R1 ack", 32'(ack_o), 0);
    chk("R1 wake", 32'(wake_o), 0);
    chk("R1 vec", 32'(vec_o), 0);
    rst = 1'b0;
    // full device sweep, no software requests
    for (int p = 0; p < 8; p++)
      for (int d = 0; d < 128; d++)
        run_one(p, 8'h00, 8'(d << 1), d[0], d[1]);
    // full software sweep against a spread of device patterns
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 128; s++)
        for (int d = 0; d < 128; d += 9)
          run_one(p, 8'(s << 1), 8'(d << 1), s[0] ^ d[0], s[2]);
    // R9: only low bits and level-0 device set
    run_one(0, 8'h00, 8'h00, 1'b1, 1'b1);
    // R7: strobe low, requests present, outputs stay quiet
    @(negedge clk);
    cpu_pri_i = '0; pirq_i = 16'hFF00; dev_req_i = 8'hFE; eval_i = 1'b0;
    @(negedge clk);
    chk("R7 take", 32'(take_o), 0);
    chk("R7 ack", 32'(ack_o), 0);
    chk("R7 wake", 32'(wake_o), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule